// File: doc/BRIEF.md
# LCD Frame Scan Timing Generator

This block produces the row-scan timing for a passive matrix liquid crystal panel. A display tick is taken either from an internal oscillator enable or from an external line clock, depending on the master/slave and clock-select pins. Each tick advances a line counter through a frame of `NUM_LINES` lines. On the last line of a frame the counter wraps, and the frame-alternating polarity signal flips on that same tick, so the panel is driven with AC polarity over two frames.

On every tick the block reads one row of pixel data from its own scan-side read port of a dual-port display RAM and loads it into an output latch. While the next row is pending, the read address already points at it. Between ticks the displayed row depends only on the latch, so software writes to the RAM through the other port never disturb the panel. Display-off, all-points-on and reverse settings act on the latch output only. The block turns the resulting pixels, the one-hot common select and the frame polarity into 2-bit drive level codes for each segment and each common electrode.

Top module: `lcd_scan_timing`

## Requirements
- R1: A display tick is `osc_tick_i` when `master_i` and `clk_sel_i` are both high, and `ext_cl_i` in every other pin combination. A pulse on the unselected source does not advance the scan.
- R2: After reset the line is 1, `fr_o` is low, the latch holds all zeros, `lat_stb_o` is low and `ram_addr_o` is 1.
- R3: Each tick advances the line by one, from 1 up to `NUM_LINES` (65 by default). The tick after line `NUM_LINES` returns it to 1.
- R4: `fr_o` inverts on exactly the tick that wraps the line from `NUM_LINES` to 1, and holds at all other times.
- R5: `ram_addr_o` is the row index of the next line: equal to the current line, or 0 when the line is `NUM_LINES`. On a tick the latch loads `ram_rdata_i`, so line L shows RAM row L-1.
- R6: Changes on `ram_rdata_i` between ticks leave the segment outputs unchanged.
- R7: Modifier priority: display off (`disp_on_i` low) blanks every pixel; otherwise `all_on_i` lights every pixel; otherwise `rev_i` inverts the latched bits; otherwise latched bits pass through.
- R8: With the display on, `com_sel_o` has exactly bit L-1 set for line L. With the display off, `com_sel_o` is all zeros.
- R9: Segment code (segment i at bits 2i+1:2i): a lit pixel gives 2'b11 when `fr_o` is low and 2'b00 when it is high. An unlit pixel gives 2'b01 when `fr_o` is low and 2'b10 when it is high.
- R10: Common code (common j at bits 2j+1:2j): a selected common gives 2'b00 when `fr_o` is low and 2'b11 when it is high. A deselected common gives 2'b10 when `fr_o` is low and 2'b01 when it is high.
- R11: `lat_stb_o` is high for exactly the one clock cycle after each tick, the same cycle in which the new line, polarity and latched row first appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Master (1) / slave (0) mode |
| clk_sel_i | input | 1 | Clock select: 1 allows internal oscillator |
| osc_tick_i | input | 1 | Internal oscillator enable pulse, one clock wide |
| ext_cl_i | input | 1 | External line clock pulse, one clock wide |
| disp_on_i | input | 1 | Display enable |
| all_on_i | input | 1 | Force all pixels lit |
| rev_i | input | 1 | Invert latched pixels |
| ram_addr_o | output | $clog2(NUM_LINES+1) | Scan-side RAM row address |
| ram_rdata_i | input | NUM_SEG | Scan-side RAM row data |
| lat_stb_o | output | 1 | Latch strobe |
| fr_o | output | 1 | Frame polarity signal |
| com_sel_o | output | NUM_LINES | One-hot common select |
| seg_lvl_o | output | 2*NUM_SEG | Segment drive level codes |
| com_lvl_o | output | 2*NUM_LINES | Common drive level codes |

## Verification
A tick raised before a clock edge updates the line, `fr_o`, the latched row and `lat_stb_o` at that edge. Every port that follows from them is decoded combinationally, so all results are due one edge after the tick. The bench drives each tick on a falling edge, lets exactly one rising edge pass, and samples on the following falling edge. It then samples again one cycle later to confirm that the strobe has dropped. Modifier and RAM-data changes are applied between ticks and checked after a settling edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_LO  = 2'b00;
  localparam lvl_t LVL_MLO = 2'b01;
  localparam lvl_t LVL_MHI = 2'b10;
  localparam lvl_t LVL_HI  = 2'b11;

  function automatic lvl_t seg_code(input logic pix, input logic fr);
    if (pix) return fr ? LVL_LO : LVL_HI;
    return fr ? LVL_MHI : LVL_MLO;
  endfunction

  function automatic lvl_t com_code(input logic sel, input logic fr);
    if (sel) return fr ? LVL_HI : LVL_LO;
    return fr ? LVL_MLO : LVL_MHI;
  endfunction
endpackage

// File: rtl/lcd_clk_src.sv
module lcd_clk_src (
  input  logic master_i,
  input  logic clk_sel_i,
  input  logic osc_tick_i,
  input  logic ext_cl_i,
  output logic tick_o
);
  logic use_osc;
  assign use_osc = master_i & clk_sel_i;
  assign tick_o  = use_osc ? osc_tick_i : ext_cl_i;
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
  parameter int NUM_LINES = 65,
  localparam int LW = $clog2(NUM_LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [LW-1:0] line_o,
  output logic [LW-1:0] next_row_o,
  output logic          fr_o,
  output logic          stb_o
);
  localparam logic [LW-1:0] LAST = LW'(NUM_LINES);

  logic [LW-1:0] line_q;
  logic          fr_q, stb_q, wrap;

  assign wrap = (line_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LW'(1);
      fr_q   <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      stb_q <= tick_i;
      if (tick_i) begin
        line_q <= wrap ? LW'(1) : line_q + LW'(1);
        if (wrap) fr_q <= ~fr_q;
      end
    end
  end

  // row index of the line that the next tick enters
  assign next_row_o = wrap ? '0 : line_q;
  assign line_o     = line_q;
  assign fr_o       = fr_q;
  assign stb_o      = stb_q;
endmodule

// File: rtl/lcd_row_latch.sv
module lcd_row_latch #(
  parameter int NUM_SEG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [NUM_SEG-1:0] row_i,
  input  logic               disp_on_i,
  input  logic               all_on_i,
  input  logic               rev_i,
  output logic [NUM_SEG-1:0] pix_o
);
  logic [NUM_SEG-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (load_i) row_q <= row_i;
  end

  // modifiers touch only the latch output
  always_comb begin
    if (!disp_on_i)    pix_o = '0;
    else if (all_on_i) pix_o = '1;
    else if (rev_i)    pix_o = ~row_q;
    else               pix_o = row_q;
  end
endmodule

// File: rtl/lcd_drive_enc.sv
module lcd_drive_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG   = 8,
  parameter int NUM_LINES = 65,
  localparam int LW = $clog2(NUM_LINES + 1)
) (
  input  logic [NUM_SEG-1:0]     pix_i,
  input  logic [LW-1:0]          line_i,
  input  logic                   fr_i,
  input  logic                   disp_on_i,
  output logic [NUM_LINES-1:0]   com_sel_o,
  output logic [2*NUM_SEG-1:0]   seg_lvl_o,
  output logic [2*NUM_LINES-1:0] com_lvl_o
);
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    assign seg_lvl_o[2*i +: 2] = seg_code(pix_i[i], fr_i);
  end

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_com
    assign com_sel_o[j]         = disp_on_i && (line_i == LW'(j + 1));
    assign com_lvl_o[2*j +: 2]  = com_code(com_sel_o[j], fr_i);
  end
endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
  parameter int NUM_SEG   = 8,
  parameter int NUM_LINES = 65,
  localparam int LW = $clog2(NUM_LINES + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   master_i,
  input  logic                   clk_sel_i,
  input  logic                   osc_tick_i,
  input  logic                   ext_cl_i,
  input  logic                   disp_on_i,
  input  logic                   all_on_i,
  input  logic                   rev_i,
  output logic [LW-1:0]          ram_addr_o,
  input  logic [NUM_SEG-1:0]     ram_rdata_i,
  output logic                   lat_stb_o,
  output logic                   fr_o,
  output logic [NUM_LINES-1:0]   com_sel_o,
  output logic [2*NUM_SEG-1:0]   seg_lvl_o,
  output logic [2*NUM_LINES-1:0] com_lvl_o
);
  logic               tick;
  logic [LW-1:0]      line;
  logic [NUM_SEG-1:0] pix;

  lcd_clk_src u_src (
    .master_i  (master_i),
    .clk_sel_i (clk_sel_i),
    .osc_tick_i(osc_tick_i),
    .ext_cl_i  (ext_cl_i),
    .tick_o    (tick)
  );

  lcd_line_ctr #(.NUM_LINES(NUM_LINES)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .line_o    (line),
    .next_row_o(ram_addr_o),
    .fr_o      (fr_o),
    .stb_o     (lat_stb_o)
  );

  lcd_row_latch #(.NUM_SEG(NUM_SEG)) u_lat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tick),
    .row_i    (ram_rdata_i),
    .disp_on_i(disp_on_i),
    .all_on_i (all_on_i),
    .rev_i    (rev_i),
    .pix_o    (pix)
  );

  lcd_drive_enc #(.NUM_SEG(NUM_SEG), .NUM_LINES(NUM_LINES)) u_enc (
    .pix_i    (pix),
    .line_i   (line),
    .fr_i     (fr_o),
    .disp_on_i(disp_on_i),
    .com_sel_o(com_sel_o),
    .seg_lvl_o(seg_lvl_o),
    .com_lvl_o(com_lvl_o)
  );
endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker #(
  parameter int NUM_SEG   = 8,
  parameter int NUM_LINES = 65,
  localparam int LW = $clog2(NUM_LINES + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 master_i,
  input logic                 clk_sel_i,
  input logic                 osc_tick_i,
  input logic                 ext_cl_i,
  input logic                 disp_on_i,
  input logic                 all_on_i,
  input logic                 rev_i,
  input logic [LW-1:0]        line,
  input logic                 lat_stb_o,
  input logic                 fr_o,
  input logic [NUM_LINES-1:0] com_sel_o,
  input logic [2*NUM_SEG-1:0] seg_lvl_o
);
  localparam logic [LW-1:0] LAST = LW'(NUM_LINES);

  a_r3_line_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line >= LW'(1) && line <= LAST);

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_stb_o |-> (line == $past(line) + LW'(1)) ||
                  ($past(line) == LAST && line == LW'(1)));

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lat_stb_o |-> $stable(line));

  a_r4_fr_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_o != $past(fr_o)) |-> (lat_stb_o && line == LW'(1) && $past(line) == LAST));

  a_r1_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_stb_o |-> $past((master_i && clk_sel_i) ? osc_tick_i : ext_cl_i));

  a_r6_hold_segs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lat_stb_o && $stable({disp_on_i, all_on_i, rev_i})) |-> $stable(seg_lvl_o));

  a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_on_i |-> $countones(com_sel_o) == 1);

  a_r8_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_i |-> com_sel_o == '0);

  a_r7_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_i |-> seg_lvl_o == {NUM_SEG{fr_o ? 2'b10 : 2'b01}});
endmodule

bind lcd_scan_timing lcd_scan_checker #(.NUM_SEG(NUM_SEG), .NUM_LINES(NUM_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .clk_sel_i (clk_sel_i),
  .osc_tick_i(osc_tick_i),
  .ext_cl_i  (ext_cl_i),
  .disp_on_i (disp_on_i),
  .all_on_i  (all_on_i),
  .rev_i     (rev_i),
  .line      (line),
  .lat_stb_o (lat_stb_o),
  .fr_o      (fr_o),
  .com_sel_o (com_sel_o),
  .seg_lvl_o (seg_lvl_o)
);

// File: tb/tb_lcd_scan_timing.sv
module tb_lcd_scan_timing;
  localparam int NS = 8;
  localparam int NL = 65;
  localparam int LW = $clog2(NL + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic master = 1'b1, csel = 1'b1, osc = 1'b0, ext = 1'b0;
  logic don = 1'b1, allon = 1'b0, rev = 1'b0;
  logic [LW-1:0]   raddr;
  logic [NS-1:0]   rdata;
  logic            stb, fr;
  logic [NL-1:0]   com_sel;
  logic [2*NS-1:0] seg_lvl;
  logic [2*NL-1:0] com_lvl;

  logic [NS-1:0] mem [NL];
  int checks = 0, errors = 0;
  int exp_line = 1;
  logic exp_fr = 1'b0;

  always #2ns clk = ~clk;
  assign rdata = (raddr < LW'(NL)) ? mem[raddr] : '0;

  lcd_scan_timing #(.NUM_SEG(NS), .NUM_LINES(NL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(master), .clk_sel_i(csel),
    .osc_tick_i(osc), .ext_cl_i(ext), .disp_on_i(don), .all_on_i(allon),
    .rev_i(rev), .ram_addr_o(raddr), .ram_rdata_i(rdata), .lat_stb_o(stb),
    .fr_o(fr), .com_sel_o(com_sel), .seg_lvl_o(seg_lvl), .com_lvl_o(com_lvl)
  );

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*NS-1:0] exp_seg(logic [NS-1:0] row, logic f,
                                              logic on, logic al, logic rv);
    logic [2*NS-1:0] v;
    for (int i = 0; i < NS; i++) begin
      logic p;
      p = !on ? 1'b0 : al ? 1'b1 : rv ? ~row[i] : row[i];
      v[2*i +: 2] = p ? (f ? 2'b00 : 2'b11) : (f ? 2'b10 : 2'b01);
    end
    return v;
  endfunction

  function automatic logic [NL-1:0] exp_com(int ln, logic on);
    logic [NL-1:0] v = '0;
    if (on) v[ln-1] = 1'b1;
    return v;
  endfunction

  function automatic logic [2*NL-1:0] exp_clvl(int ln, logic on, logic f);
    logic [2*NL-1:0] v;
    for (int j = 0; j < NL; j++)
      v[2*j +: 2] = (on && j == ln - 1) ? (f ? 2'b11 : 2'b00) : (f ? 2'b01 : 2'b10);
    return v;
  endfunction

  // one pulse on the chosen source; sample one edge later
  task automatic pulse(bit use_osc, bit use_ext);
    @(negedge clk); osc = use_osc; ext = use_ext;
    @(negedge clk); osc = 1'b0; ext = 1'b0;
  endtask

  task automatic adv();
    if (exp_line == NL) begin exp_line = 1; exp_fr = ~exp_fr; end
    else exp_line++;
  endtask

  task automatic t_reset();
    chk("R2 line", com_sel, exp_com(1, 1'b1));
    chk("R2 fr", fr, 1'b0);
    chk("R2 stb", stb, 1'b0);
    chk("R2 addr", raddr, 1);
    chk("R2 latch", seg_lvl, exp_seg('0, 1'b0, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_source();
    master = 1'b1; csel = 1'b1;
    pulse(0, 1); chk("R1 ext ignored in master/osc", com_sel, exp_com(exp_line, 1'b1));
    pulse(1, 0); adv(); chk("R1 osc used", com_sel, exp_com(exp_line, 1'b1));
    csel = 1'b0;
    pulse(1, 0); chk("R1 osc ignored clk_sel low", com_sel, exp_com(exp_line, 1'b1));
    pulse(0, 1); adv(); chk("R1 ext used clk_sel low", com_sel, exp_com(exp_line, 1'b1));
    master = 1'b0; csel = 1'b1;
    pulse(1, 0); chk("R1 osc ignored slave", com_sel, exp_com(exp_line, 1'b1));
    pulse(0, 1); adv(); chk("R1 ext used slave", com_sel, exp_com(exp_line, 1'b1));
    master = 1'b1; csel = 1'b1;
  endtask

  // two full frames: line, FR, strobe, latched row, address every tick
  task automatic t_frames();
    for (int n = 0; n < 2 * NL + 3; n++) begin
      @(negedge clk); osc = 1'b1;
      @(negedge clk); osc = 1'b0;
      adv();
      chk("R3 line", com_sel, exp_com(exp_line, 1'b1));
      chk("R4 fr", fr, exp_fr);
      chk("R11 stb high", stb, 1'b1);
      chk("R5 addr", raddr, exp_line % NL);
      chk("R5 row", seg_lvl, exp_seg(mem[exp_line-1], exp_fr, 1'b1, 1'b0, 1'b0));
      chk("R10 com codes", com_lvl, exp_clvl(exp_line, 1'b1, exp_fr));
      @(negedge clk);
      chk("R11 stb low", stb, 1'b0);
      chk("R4 fr hold", fr, exp_fr);
    end
  endtask

  task automatic t_ram_indep();
    logic [NS-1:0] shown;
    shown = mem[exp_line-1];
    for (int r = 0; r < NL; r++) mem[r] = ~mem[r];
    repeat (3) @(negedge clk);
    chk("R6 segs unchanged", seg_lvl, exp_seg(shown, exp_fr, 1'b1, 1'b0, 1'b0));
    pulse(1, 0); adv();
    chk("R6 new row after tick", seg_lvl, exp_seg(mem[exp_line-1], exp_fr, 1'b1, 1'b0, 1'b0));
  endtask

  task automatic t_modifiers();
    logic [NS-1:0] row;
    row = mem[exp_line-1];
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); don = ~k[0]; allon = k[1]; rev = k[2];
      @(negedge clk);
      chk("R7 modifier", seg_lvl, exp_seg(row, exp_fr, don, allon, rev));
      chk("R9 seg code", seg_lvl, exp_seg(row, exp_fr, don, allon, rev));
      chk("R8 com select", com_sel, exp_com(exp_line, don));
      chk("R10 com level", com_lvl, exp_clvl(exp_line, don, exp_fr));
    end
    @(negedge clk); don = 1'b1; allon = 1'b0; rev = 1'b0;
    @(negedge clk);
    chk("R7 ram untouched", seg_lvl, exp_seg(row, exp_fr, 1'b1, 1'b0, 1'b0));
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < NL; r++) mem[r] = NS'(r * 37 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_source();
    t_frames();
    t_ram_indep();
    t_modifiers();
    rev = 1'b1;
    while (exp_line != NL) begin pulse(1, 0); adv(); end
    t_modifiers();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule